// File: doc/BRIEF.md
# Maskable Host Interrupt Generator with Timed Re-pulse

This block produces one active-low interrupt line for a host processor. Four event sources feed it: key events, general-purpose input changes, completion of the keypad unlock sequence, and overflow of the event queue. Each event sets a sticky status bit. The host clears a bit by writing a 1 to it. Each source has its own enable, and only enabled status bits can pull the line low. A disabled source still records its status.

Two configuration inputs shape the behaviour. The re-pulse mode decides what the line does when the host clears status while events are still pending. In hold mode the line simply stays low. In re-pulse mode the line is released for a fixed gap of about 50 microseconds. It then drops again, so an edge-triggered host sees a fresh interrupt. The gap length in clock cycles is derived from the clock frequency parameter.

The lock-filter input decides whether input-change events are recorded while the keypad is locked. While the event queue reports that it is non-empty, the key-event status bit refuses to clear. This keeps the queued key events visible to the host.

Top module: `irq_gen`

## Requirements
- R1: After reset all status bits are 0 and `irq_n_o` is 1. `irq_n_o` is 0 exactly when some status bit and its enable are both 1 and no re-pulse gap is running. Bit positions in `status_o`, `src_en_i` and `clr_mask_i` are: 0 key, 1 input change, 2 unlock, 3 overflow.
- R2: A source whose enable bit is 0 never drives `irq_n_o` low. Its status bit is still recorded. Setting the enable afterwards lowers the line in the same cycle.
- R3: A one-cycle event pulse sets its status bit at the next clock edge. The bit stays set until a clear with a 1 in its `clr_mask_i` position.
- R4: When an event and a clear of the same bit occur in the same cycle, the bit stays set.
- R5: With `gpi_lock_ignore_i`=1 and `keypad_locked_i`=1, input-change events are not recorded. With `gpi_lock_ignore_i`=0 they are recorded while locked.
- R6: While `queue_nonempty_i`=1, a clear of the key status bit (bit 0) is refused and the bit stays set.
- R7: With `repulse_mode_i`=0, a clear attempt while events are pending leaves `irq_n_o` continuously low.
- R8: With `repulse_mode_i`=1, a clear attempt while events are pending has this effect. The line is high for exactly GAP_CYCLES cycles after the clearing edge. It then returns low if an enabled status bit remains. Events are pending when `queue_nonempty_i`=1 or an enabled key or input-change bit remains set after the clear.
- R9: With `repulse_mode_i`=1, a clear attempt with nothing pending starts no gap. A new event right after it drives the line low at once.
- R10: The overflow status bit (bit 3) is set by `ovf_evt_i`. It asserts the line only while its enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_evt_i | input | 1 | Key press or release event pulse |
| gpi_evt_i | input | 1 | General-purpose input change pulse |
| unlock_evt_i | input | 1 | Unlock sequence completed pulse |
| ovf_evt_i | input | 1 | Event queue overflow pulse |
| keypad_locked_i | input | 1 | Keypad is currently locked |
| queue_nonempty_i | input | 1 | Event queue holds unread entries |
| src_en_i | input | 4 | Per-source interrupt enables |
| repulse_mode_i | input | 1 | 0 hold line low, 1 timed release on clear while pending |
| gpi_lock_ignore_i | input | 1 | 1 drops input changes while locked |
| clr_we_i | input | 1 | Host clear strobe |
| clr_mask_i | input | 4 | Write-one-to-clear mask |
| irq_n_o | output | 1 | Active-low interrupt line |
| status_o | output | 4 | Sticky status bits |

## Verification
The assertions assume that event inputs, the clear strobe and the mask are synchronous to `clk` and stable across each rising edge. They also assume that only the `gpi_evt_i` pulse can set the input-change bit. The timer checks assume that the gap length is at least one cycle. The bench drives every input on the falling edge and holds it for a whole cycle. Events are one-cycle pulses. `queue_nonempty_i` and the mode inputs change only between scenarios, never inside a clear or a gap window.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NUM_SRC  = 4;
    localparam int SRC_KEY  = 0;
    localparam int SRC_GPI  = 1;
    localparam int SRC_UNLK = 2;
    localparam int SRC_OVF  = 3;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // Sources whose remaining status counts as "pending" for the re-pulse decision
    localparam src_vec_t PEND_SRC_MASK = src_vec_t'((1 << SRC_KEY) | (1 << SRC_GPI));

    typedef struct packed {
        src_vec_t bits;
    } stat_state_t;

endpackage

// File: rtl/irq_event_qual.sv
module irq_event_qual
    import irq_pkg::*;
(
    input  logic     key_evt_i,
    input  logic     gpi_evt_i,
    input  logic     unlock_evt_i,
    input  logic     ovf_evt_i,
    input  logic     keypad_locked_i,
    input  logic     gpi_lock_ignore_i,
    output src_vec_t set_vec_o
);

    logic gpi_block;

    always_comb begin
        gpi_block                = keypad_locked_i & gpi_lock_ignore_i;
        set_vec_o                = '0;
        set_vec_o[SRC_KEY]       = key_evt_i;
        set_vec_o[SRC_GPI]       = gpi_evt_i & ~gpi_block;
        set_vec_o[SRC_UNLK]      = unlock_evt_i;
        set_vec_o[SRC_OVF]       = ovf_evt_i;
    end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_vec_i,
    input  src_vec_t hold_vec_i,
    input  logic     clr_we_i,
    input  src_vec_t clr_mask_i,
    output src_vec_t status_q_o,
    output src_vec_t status_d_o,
    output logic     clr_hit_o
);

    stat_state_t st_d, st_q;
    src_vec_t    clr_eff;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            clr_eff[i] = clr_we_i & clr_mask_i[i] & ~hold_vec_i[i];
            if (set_vec_i[i]) begin
                st_d.bits[i] = 1'b1;
            end else if (clr_eff[i]) begin
                st_d.bits[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_q_o = st_q.bits;
    assign status_d_o = st_d.bits;
    assign clr_hit_o  = clr_we_i & |(clr_mask_i & st_q.bits);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        // R3: a set bit survives every cycle without a clear of that bit
        p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.bits[g] && !(clr_we_i && clr_mask_i[g])) |=> st_q.bits[g]);
        // R4: an event wins over a clear in the same cycle
        p_collide_r4: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec_i[g] |=> st_q.bits[g]);
        // R6: a held bit cannot be cleared
        p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_vec_i[g] && st_q.bits[g]) |=> st_q.bits[g]);
    end

endmodule

// File: rtl/irq_gap_timer.sv
module irq_gap_timer #(
    parameter int GAP_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o
);

    localparam int CW = $clog2(GAP_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(GAP_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } gap_state_t;

    gap_state_t gs_d, gs_q;

    always_comb begin
        gs_d = gs_q;
        if (start_i) begin
            gs_d.cnt = LOAD_VAL;
        end else if (gs_q.cnt != '0) begin
            gs_d.cnt = gs_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gs_q <= '0;
        end else begin
            gs_q <= gs_d;
        end
    end

    assign active_o = (gs_q.cnt != '0);

    // R8: a start loads the full gap length
    p_gap_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (gs_q.cnt == LOAD_VAL));
    // R8: a running gap counts down by one per cycle
    p_gap_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gs_q.cnt != '0 && !start_i) |=> (gs_q.cnt == CW'($past(gs_q.cnt) - 1'b1)));

endmodule

// File: rtl/irq_gen.sv
module irq_gen
    import irq_pkg::*;
#(
    parameter int CLK_FREQ_HZ = 2_000_000,
    parameter int GAP_NS      = 50_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_evt_i,
    input  logic       gpi_evt_i,
    input  logic       unlock_evt_i,
    input  logic       ovf_evt_i,
    input  logic       keypad_locked_i,
    input  logic       queue_nonempty_i,
    input  logic [3:0] src_en_i,
    input  logic       repulse_mode_i,
    input  logic       gpi_lock_ignore_i,
    input  logic       clr_we_i,
    input  logic [3:0] clr_mask_i,
    output logic       irq_n_o,
    output logic [3:0] status_o
);

    localparam int GAP_RAW    = (CLK_FREQ_HZ / 1000) * GAP_NS / 1_000_000;
    localparam int GAP_CYCLES = (GAP_RAW < 1) ? 1 : GAP_RAW;

    src_vec_t set_vec, hold_vec, stat_q, stat_d, en_vec;
    logic     clr_hit, pending, gap_start, gap_active, irq_req;

    irq_event_qual u_qual (
        .key_evt_i         (key_evt_i),
        .gpi_evt_i         (gpi_evt_i),
        .unlock_evt_i      (unlock_evt_i),
        .ovf_evt_i         (ovf_evt_i),
        .keypad_locked_i   (keypad_locked_i),
        .gpi_lock_ignore_i (gpi_lock_ignore_i),
        .set_vec_o         (set_vec)
    );

    always_comb begin
        en_vec            = src_vec_t'(src_en_i);
        hold_vec          = '0;
        hold_vec[SRC_KEY] = queue_nonempty_i;
    end

    irq_status_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec_i  (set_vec),
        .hold_vec_i (hold_vec),
        .clr_we_i   (clr_we_i),
        .clr_mask_i (src_vec_t'(clr_mask_i)),
        .status_q_o (stat_q),
        .status_d_o (stat_d),
        .clr_hit_o  (clr_hit)
    );

    always_comb begin
        pending   = queue_nonempty_i | (|(stat_d & en_vec & PEND_SRC_MASK));
        gap_start = repulse_mode_i & clr_hit & pending;
        irq_req   = |(stat_q & en_vec);
    end

    irq_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (gap_start),
        .active_o (gap_active)
    );

    assign irq_n_o  = ~(irq_req & ~gap_active);
    assign status_o = stat_q;

    // R2: no enabled status bit means the line is released
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & src_en_i) == 4'b0) |-> irq_n_o);
    // R5: input changes are dropped while locked in filter mode
    p_gpi_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (keypad_locked_i && gpi_lock_ignore_i && !status_o[SRC_GPI]) |=> !status_o[SRC_GPI]);
    // R7: hold mode never opens a gap
    p_hold_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!repulse_mode_i && !gap_active) |=> !gap_active);

endmodule

// File: tb/irq_gen_bench.sv
module irq_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 2_000_000;
    localparam int GAP_N      = (CLK_HZ / 1000) * 50_000 / 1_000_000;

    logic       clk, rst_n;
    logic       key_evt, gpi_evt, unlock_evt, ovf_evt;
    logic       locked, qne, repulse, gpi_ign, clr_we;
    logic [3:0] src_en, clr_mask, status;
    logic       irq_n;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    irq_gen #(.CLK_FREQ_HZ(CLK_HZ), .GAP_NS(50_000)) u_irq_gen (
        .clk(clk), .rst_n(rst_n),
        .key_evt_i(key_evt), .gpi_evt_i(gpi_evt), .unlock_evt_i(unlock_evt), .ovf_evt_i(ovf_evt),
        .keypad_locked_i(locked), .queue_nonempty_i(qne), .src_en_i(src_en),
        .repulse_mode_i(repulse), .gpi_lock_ignore_i(gpi_ign),
        .clr_we_i(clr_we), .clr_mask_i(clr_mask),
        .irq_n_o(irq_n), .status_o(status)
    );

    initial begin
        clk = 0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic pulse(input int src);
        case (src)
            0: key_evt = 1;
            1: gpi_evt = 1;
            2: unlock_evt = 1;
            default: ovf_evt = 1;
        endcase
        step();
        key_evt = 0; gpi_evt = 0; unlock_evt = 0; ovf_evt = 0;
    endtask

    task automatic do_clear(input logic [3:0] m);
        clr_we = 1; clr_mask = m;
        step();
        clr_we = 0; clr_mask = 0;
    endtask

    task automatic cleanup();
        qne = 0; repulse = 0; locked = 0; gpi_ign = 0;
        do_clear(4'hF);
        src_en = 0;
        step();
    endtask

    task automatic t_reset();
        check(status == 4'h0, "R1 reset status", status, 0);
        check(irq_n == 1'b1, "R1 reset line", irq_n, 1);
    endtask

    task automatic t_key_basic();
        src_en = 4'b0001;
        pulse(0);
        check(status == 4'b0001, "R3 key set", status, 1);
        check(irq_n == 1'b0, "R1 line low", irq_n, 0);
        repeat (4) step();
        check(status[0] == 1'b1, "R3 sticky", status[0], 1);
        do_clear(4'b0001);
        check(status == 4'h0, "R3 cleared", status, 0);
        check(irq_n == 1'b1, "R1 line released", irq_n, 1);
        cleanup();
    endtask

    task automatic t_disabled();
        src_en = 4'b0000;
        pulse(1);
        check(status == 4'b0010, "R2 status recorded", status, 2);
        check(irq_n == 1'b1, "R2 masked line high", irq_n, 1);
        src_en = 4'b0010;
        #1;
        check(irq_n == 1'b0, "R2 enable lowers line", irq_n, 0);
        cleanup();
    endtask

    task automatic t_collide();
        src_en = 4'b0001;
        pulse(0);
        key_evt = 1; clr_we = 1; clr_mask = 4'b0001;
        step();
        key_evt = 0; clr_we = 0; clr_mask = 0;
        check(status[0] == 1'b1, "R4 event beats clear", status[0], 1);
        cleanup();
    endtask

    task automatic t_gpi_lock();
        src_en = 4'b0010; locked = 1; gpi_ign = 1;
        pulse(1);
        check(status[1] == 1'b0, "R5 dropped while locked", status[1], 0);
        check(irq_n == 1'b1, "R5 line high", irq_n, 1);
        gpi_ign = 0;
        pulse(1);
        check(status[1] == 1'b1, "R5 tracked while locked", status[1], 1);
        cleanup();
    endtask

    task automatic t_hold_mode();
        src_en = 4'b0001; repulse = 0; qne = 1;
        pulse(0);
        do_clear(4'b0001);
        check(status[0] == 1'b1, "R6 clear refused", status[0], 1);
        check(irq_n == 1'b0, "R7 line held", irq_n, 0);
        for (int k = 0; k < 5; k++) begin
            step();
            check(irq_n == 1'b0, "R7 line stays low", irq_n, 0);
        end
        qne = 0;
        do_clear(4'b0001);
        check(status[0] == 1'b0, "R6 clear after drain", status[0], 0);
        cleanup();
    endtask

    task automatic t_repulse();
        int highs = 0;
        src_en = 4'b0001; repulse = 1; qne = 1;
        pulse(0);
        clr_we = 1; clr_mask = 4'b0001;
        step();
        clr_we = 0; clr_mask = 0;
        check(irq_n == 1'b1, "R8 line released on clear", irq_n, 1);
        if (irq_n) highs++;
        for (int k = 2; k <= GAP_N; k++) begin
            step();
            if (irq_n) highs++;
        end
        check(highs == GAP_N, "R8 gap length", highs, GAP_N);
        step();
        check(irq_n == 1'b0, "R8 line reasserts", irq_n, 0);
        check(status[0] == 1'b1, "R8 key still pending", status[0], 1);
        cleanup();
    endtask

    task automatic t_no_pending();
        src_en = 4'b0100; repulse = 1; qne = 0;
        pulse(2);
        check(irq_n == 1'b0, "R9 unlock raises line", irq_n, 0);
        do_clear(4'b0100);
        check(irq_n == 1'b1, "R9 released", irq_n, 1);
        step();
        pulse(2);
        check(irq_n == 1'b0, "R9 no gap blocks new event", irq_n, 0);
        cleanup();
    endtask

    task automatic t_ovf();
        src_en = 4'b0111;
        pulse(3);
        check(status == 4'b1000, "R10 overflow recorded", status, 8);
        check(irq_n == 1'b1, "R10 disabled overflow quiet", irq_n, 1);
        src_en = 4'b1000;
        #1;
        check(irq_n == 1'b0, "R10 enabled overflow drives", irq_n, 0);
        cleanup();
    endtask

    initial begin
        rst_n = 0;
        key_evt = 0; gpi_evt = 0; unlock_evt = 0; ovf_evt = 0;
        locked = 0; qne = 0; src_en = 0; repulse = 0; gpi_ign = 0;
        clr_we = 0; clr_mask = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        t_reset();
        t_key_basic();
        t_disabled();
        t_collide();
        t_gpi_lock();
        t_hold_mode();
        t_repulse();
        t_no_pending();
        t_ovf();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

endmodule